// File: doc/BRIEF.md
# Triggered SPI Command Replay Sequencer

This block keeps a short list of SPI command words and a separate list of SDO data words. Both lists are loaded in advance through a simple write port while the block is disabled. Once the block is enabled, each rising edge on the trigger input replays both lists to a downstream SPI command-execution engine. Commands leave on a valid/ready stream and SDO words leave on a second valid/ready stream. Each stream walks its own list independently, so stalls on one stream do not hold up the other.

The trigger may come from the engine's own clock domain, or it may be asynchronous. A parameter inserts a two-flop synchronizer for the asynchronous case and leaves it out for same-clock builds. When ready stays high, commands stream at one per clock. SDI data coming back from the engine is passed straight through to an output stream, with no register in the path.

Top module: `spi_replay_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `cmd_valid` and `sdo_valid` are low.
- R2: With `ASYNC_TRIG=0`, suppose `trig_in` is sampled high at a clock edge after being low at the edge before, while the block is enabled and idle. Then `cmd_valid` is high right after that same edge, which is one cycle of latency. `cmd_data` then carries command entry 0.
- R3: When the SDO count is non-zero, `sdo_valid` rises in the same cycle as `cmd_valid` and carries SDO entry 0.
- R4: With `ASYNC_TRIG=1`, the trigger passes through two synchronizing flops. `cmd_valid` therefore rises three edges after the first edge that samples `trig_in` high, and is still low after the second.
- R5: While `cmd_ready` stays high, one command is accepted per clock. The commands come out in address order, 0 up to count−1, with no gaps.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` does not change. The same holds for `sdo_valid`/`sdo_data` with `sdo_ready`.
- R7: The SDO pointer advances only on an SDO handshake. It does not depend on command handshakes.
- R8: `sdi_out_valid`/`sdi_out_data` equal `sdi_in_valid`/`sdi_in_data`, and `sdi_in_ready` equals `sdi_out_ready`, within the same cycle.
- R9: Trigger edges that arrive while either list is still being replayed are ignored.
- R10: Write-port writes made while `enable` is high are ignored. Trigger edges that arrive while `enable` is low are ignored.
- R11: After exactly `count` handshakes a stream's valid drops. Each new sequence starts again from entry 0.
- R12: The write port uses `wr_sel` as follows: 0 writes command memory, 1 writes SDO memory, 2 writes the command count and 3 writes the SDO count. A count is taken from `wr_data`, and a value above 16 is stored as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Arms triggers; low allows preloading |
| trig_in | input | 1 | Trigger, rising edge starts a sequence |
| wr_en | input | 1 | Write strobe for preload port |
| wr_sel | input | 2 | Target: 0 cmd mem, 1 SDO mem, 2 cmd count, 3 SDO count |
| wr_addr | input | 4 | Memory entry address |
| wr_data | input | 16 | Write data (SDO uses low 8 bits) |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready |
| cmd_data | output | 16 | Command word |
| sdo_valid | output | 1 | SDO stream valid |
| sdo_ready | input | 1 | SDO stream ready |
| sdo_data | output | 8 | SDO data word |
| sdi_in_valid | input | 1 | SDI from engine, valid |
| sdi_in_ready | output | 1 | SDI from engine, ready |
| sdi_in_data | input | 8 | SDI from engine, data |
| sdi_out_valid | output | 1 | SDI forwarded, valid |
| sdi_out_ready | input | 1 | SDI forwarded, ready |
| sdi_out_data | output | 8 | SDI forwarded, data |

## Verification
The hardest situation to reach is the one where the two pointers drift apart inside a single sequence. This needs the command stream to be stalled while the SDO stream drains, and then a fresh trigger must restart both pointers at entry 0. The bench reaches it by holding `cmd_ready` low for several cycles with `sdo_ready` high. It then releases the command stream and re-triggers the block. A second instance built with the synchronizer shares the same stimulus, and its latency is measured edge by edge.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [1:0] {
        SEL_CMD_MEM = 2'd0,
        SEL_SDO_MEM = 2'd1,
        SEL_CMD_CNT = 2'd2,
        SEL_SDO_CNT = 2'd3
    } wr_target_e;

    typedef struct packed {
        logic       cmd_mem;
        logic       sdo_mem;
        logic       cmd_cnt;
        logic       sdo_cnt;
    } wr_decode_t;

    function automatic wr_decode_t decode_write(input logic en, input logic [1:0] sel);
        wr_decode_t d;
        d.cmd_mem = en && (wr_target_e'(sel) == SEL_CMD_MEM);
        d.sdo_mem = en && (wr_target_e'(sel) == SEL_SDO_MEM);
        d.cmd_cnt = en && (wr_target_e'(sel) == SEL_CMD_CNT);
        d.sdo_cnt = en && (wr_target_e'(sel) == SEL_SDO_CNT);
        return d;
    endfunction

    function automatic logic [31:0] clamp_count(input logic [31:0] req, input logic [31:0] limit);
        return (req > limit) ? limit : req;
    endfunction

endpackage

// File: rtl/seq_trig_front.sv
module seq_trig_front #(
    parameter bit ASYNC_TRIG = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic trig_pulse
);
    logic trig_level;
    logic trig_prev;

    generate
        if (ASYNC_TRIG) begin : g_sync
            logic meta_q;
            logic stable_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q   <= 1'b0;
                    stable_q <= 1'b0;
                end else begin
                    meta_q   <= trig_in;
                    stable_q <= meta_q;
                end
            end
            assign trig_level = stable_q;
        end else begin : g_direct
            assign trig_level = trig_in;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) trig_prev <= 1'b0;
        else     trig_prev <= trig_level;
    end

    assign trig_pulse = trig_level && !trig_prev;
endmodule

// File: rtl/seq_word_store.sv
module seq_word_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/seq_list_walker.sv
module seq_list_walker #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] count,
    input  logic          ready,
    output logic          active,
    output logic [AW-1:0] ptr
);
    logic          last;
    logic [CW-1:0] ptr_ext;

    assign ptr_ext = CW'(ptr);
    assign last    = (ptr_ext + CW'(1)) == count;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ptr    <= '0;
        end else if (start) begin
            active <= (count != '0);
            ptr    <= '0;
        end else if (active && ready) begin
            if (last) active <= 1'b0;
            else      ptr    <= ptr + AW'(1);
        end
    end
endmodule

// File: rtl/spi_replay_seq.sv
module spi_replay_seq
    import spi_seq_pkg::*;
#(
    parameter int CMD_W      = 16,
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 16,
    parameter bit ASYNC_TRIG = 1'b0,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              trig_in,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [CMD_W-1:0]  cmd_data,
    output logic              sdo_valid,
    input  logic              sdo_ready,
    output logic [DATA_W-1:0] sdo_data,
    input  logic              sdi_in_valid,
    output logic              sdi_in_ready,
    input  logic [DATA_W-1:0] sdi_in_data,
    output logic              sdi_out_valid,
    input  logic              sdi_out_ready,
    output logic [DATA_W-1:0] sdi_out_data
);
    wr_decode_t    wdec;
    logic          trig_pulse;
    logic          running;
    logic          start;
    logic [CW-1:0] cmd_count;
    logic [CW-1:0] sdo_count;
    logic [AW-1:0] cmd_ptr;
    logic [AW-1:0] sdo_ptr;
    logic [CW-1:0] req_count;

    assign wdec      = decode_write(wr_en && !enable, wr_sel);
    assign req_count = CW'(clamp_count(32'(wr_data), 32'(DEPTH)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_count <= '0;
            sdo_count <= '0;
        end else begin
            if (wdec.cmd_cnt) cmd_count <= req_count;
            if (wdec.sdo_cnt) sdo_count <= req_count;
        end
    end

    seq_trig_front #(.ASYNC_TRIG(ASYNC_TRIG)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .trig_in    (trig_in),
        .trig_pulse (trig_pulse)
    );

    assign running = cmd_valid || sdo_valid;
    assign start   = trig_pulse && enable && !running;

    seq_word_store #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_cmd_mem (
        .clk     (clk),
        .wr_en   (wdec.cmd_mem),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (cmd_ptr),
        .rd_data (cmd_data)
    );

    seq_word_store #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_sdo_mem (
        .clk     (clk),
        .wr_en   (wdec.sdo_mem),
        .wr_addr (wr_addr),
        .wr_data (wr_data[DATA_W-1:0]),
        .rd_addr (sdo_ptr),
        .rd_data (sdo_data)
    );

    seq_list_walker #(.DEPTH(DEPTH)) u_cmd_walk (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .count  (cmd_count),
        .ready  (cmd_ready),
        .active (cmd_valid),
        .ptr    (cmd_ptr)
    );

    seq_list_walker #(.DEPTH(DEPTH)) u_sdo_walk (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .count  (sdo_count),
        .ready  (sdo_ready),
        .active (sdo_valid),
        .ptr    (sdo_ptr)
    );

    assign sdi_out_valid = sdi_in_valid;
    assign sdi_out_data  = sdi_in_data;
    assign sdi_in_ready  = sdi_out_ready;
endmodule

// File: rtl/spi_replay_seq_chk.sv
module spi_replay_seq_chk #(
    parameter int CMD_W      = 16,
    parameter int DATA_W     = 8,
    parameter bit ASYNC_TRIG = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              trig_in,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CMD_W-1:0]  cmd_data,
    input logic              sdo_valid,
    input logic              sdo_ready,
    input logic [DATA_W-1:0] sdo_data,
    input logic              sdi_in_valid,
    input logic              sdi_out_valid
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!cmd_valid && !sdo_valid));

    generate
        if (ASYNC_TRIG) begin : g_async_lat
            assert_async_latency_R4: assert property (@(posedge clk) disable iff (rst)
                $rose(cmd_valid) |-> $past(trig_in, 3));
        end else begin : g_sync_lat
            assert_sync_latency_R2: assert property (@(posedge clk) disable iff (rst)
                $rose(cmd_valid) |-> $past(trig_in));
        end
    endgenerate

    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    assert_sdo_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (sdo_valid && !sdo_ready) |=> (sdo_valid && $stable(sdo_data)));

    assert_sdi_pass_R8: assert property (@(posedge clk) disable iff (rst)
        sdi_out_valid == sdi_in_valid);
endmodule

bind spi_replay_seq spi_replay_seq_chk #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .ASYNC_TRIG(ASYNC_TRIG)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .trig_in       (trig_in),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_data      (cmd_data),
    .sdo_valid     (sdo_valid),
    .sdo_ready     (sdo_ready),
    .sdo_data      (sdo_data),
    .sdi_in_valid  (sdi_in_valid),
    .sdi_out_valid (sdi_out_valid)
);

// File: tb/spi_replay_seq_tb.sv
module spi_replay_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        trig_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [3:0]  wr_addr = 4'd0;
    logic [15:0] wr_data = 16'd0;
    logic        cmd_ready = 1'b1;
    logic        sdo_ready = 1'b1;
    logic        sdi_in_valid = 1'b0;
    logic [7:0]  sdi_in_data = 8'd0;
    logic        sdi_out_ready = 1'b0;

    logic        cmd_valid, sdo_valid, sdi_in_ready, sdi_out_valid;
    logic [15:0] cmd_data;
    logic [7:0]  sdo_data, sdi_out_data;
    logic        a_cmd_valid, a_sdo_valid, a_sdi_in_ready, a_sdi_out_valid;
    logic [15:0] a_cmd_data;
    logic [7:0]  a_sdo_data, a_sdi_out_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    spi_replay_seq #(.ASYNC_TRIG(1'b0)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .trig_in(trig_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
        .sdi_in_valid(sdi_in_valid), .sdi_in_ready(sdi_in_ready), .sdi_in_data(sdi_in_data),
        .sdi_out_valid(sdi_out_valid), .sdi_out_ready(sdi_out_ready), .sdi_out_data(sdi_out_data)
    );

    spi_replay_seq #(.ASYNC_TRIG(1'b1)) u_dut_async (
        .clk(clk), .rst(rst), .enable(enable), .trig_in(trig_in),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(a_cmd_valid), .cmd_ready(cmd_ready), .cmd_data(a_cmd_data),
        .sdo_valid(a_sdo_valid), .sdo_ready(sdo_ready), .sdo_data(a_sdo_data),
        .sdi_in_valid(sdi_in_valid), .sdi_in_ready(a_sdi_in_ready), .sdi_in_data(sdi_in_data),
        .sdi_out_valid(a_sdi_out_valid), .sdi_out_ready(sdi_out_ready), .sdi_out_data(a_sdi_out_data)
    );

    function automatic logic [15:0] cmd_word(input int i);
        return 16'hC100 + 16'(i * 3);
    endfunction
    function automatic logic [7:0] sdo_word(input int i);
        return 8'h50 + 8'(i * 5);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_port(input logic [1:0] sel, input logic [3:0] addr, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = data;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1;
        step();
        trig_in = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 60; k++) begin
            if (!cmd_valid && !sdo_valid && !a_cmd_valid && !a_sdo_valid) break;
            step();
        end
    endtask

    task automatic load_lists(input int ncmd, input int nsdo);
        enable = 1'b0;
        for (int i = 0; i < 16; i++) begin
            write_port(2'd0, 4'(i), cmd_word(i));
            write_port(2'd1, 4'(i), 16'(sdo_word(i)));
        end
        write_port(2'd2, 4'd0, 16'(ncmd));
        write_port(2'd3, 4'd0, 16'(nsdo));
        enable = 1'b1;
        step();
    endtask

    task automatic t_reset();
        check("R1 cmd_valid in reset", 32'(cmd_valid), 0);
        check("R1 sdo_valid in reset", 32'(sdo_valid), 0);
        rst = 1'b0;
        step();
        check("R1 cmd_valid after reset", 32'(cmd_valid), 0);
        check("R1 async cmd_valid after reset", 32'(a_cmd_valid), 0);
    endtask

    task automatic t_stream();
        cmd_ready = 1'b1; sdo_ready = 1'b1;
        pulse_trig();
        check("R2 cmd_valid one cycle after trigger", 32'(cmd_valid), 1);
        check("R3 sdo_valid same cycle", 32'(sdo_valid), 1);
        check("R3 sdo entry 0", 32'(sdo_data), 32'(sdo_word(0)));
        for (int i = 0; i < 4; i++) begin
            check("R5 cmd streaming valid", 32'(cmd_valid), 1);
            check("R5 cmd order", 32'(cmd_data), 32'(cmd_word(i)));
            if (i < 3) check("R7 sdo order", 32'(sdo_data), 32'(sdo_word(i)));
            step();
        end
        check("R11 cmd_valid drops after count", 32'(cmd_valid), 0);
        check("R11 sdo_valid drops after count", 32'(sdo_valid), 0);
        wait_idle();
    endtask

    task automatic t_backpressure();
        cmd_ready = 1'b0; sdo_ready = 1'b1;
        pulse_trig();
        check("R11 restart at entry 0", 32'(cmd_data), 32'(cmd_word(0)));
        for (int i = 0; i < 3; i++) begin
            check("R7 sdo advances alone", 32'(sdo_data), 32'(sdo_word(i)));
            step();
            check("R6 cmd held", 32'(cmd_valid), 1);
            check("R6 cmd data stable", 32'(cmd_data), 32'(cmd_word(0)));
        end
        check("R7 sdo finished while cmd stalled", 32'(sdo_valid), 0);
        pulse_trig();
        check("R9 retrigger ignored", 32'(cmd_data), 32'(cmd_word(0)));
        check("R9 sdo not restarted", 32'(sdo_valid), 0);
        cmd_ready = 1'b1;
        step();
        check("R5 cmd resumes at entry 1", 32'(cmd_data), 32'(cmd_word(1)));
        step(); step(); step();
        check("R11 cmd done after release", 32'(cmd_valid), 0);
        wait_idle();
        sdo_ready = 1'b0; cmd_ready = 1'b1;
        pulse_trig();
        step(); step();
        check("R7 sdo held without sdo handshake", 32'(sdo_data), 32'(sdo_word(0)));
        check("R6 sdo valid held", 32'(sdo_valid), 1);
        sdo_ready = 1'b1;
        wait_idle();
    endtask

    task automatic t_gating();
        write_port(2'd0, 4'd0, 16'hDEAD);
        enable = 1'b0;
        pulse_trig();
        check("R10 trigger ignored while disabled", 32'(cmd_valid), 0);
        enable = 1'b1;
        step();
        pulse_trig();
        check("R10 write while enabled ignored", 32'(cmd_data), 32'(cmd_word(0)));
        wait_idle();
    endtask

    task automatic t_saturate();
        enable = 1'b0;
        write_port(2'd2, 4'd0, 16'd31);
        enable = 1'b1;
        step();
        pulse_trig();
        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                if (cmd_valid) seen++;
                step();
            end
            check("R12 count saturates to 16", 32'(seen), 16);
        end
        wait_idle();
    endtask

    task automatic t_sdi();
        sdi_in_valid = 1'b1; sdi_in_data = 8'hA7; sdi_out_ready = 1'b1;
        #1;
        check("R8 sdi valid passthrough", 32'(sdi_out_valid), 1);
        check("R8 sdi data passthrough", 32'(sdi_out_data), 32'h A7);
        check("R8 sdi ready passthrough", 32'(sdi_in_ready), 1);
        sdi_in_valid = 1'b0; sdi_out_ready = 1'b0;
        #1;
        check("R8 sdi valid low passthrough", 32'(sdi_out_valid), 0);
    endtask

    task automatic t_async();
        cmd_ready = 1'b1; sdo_ready = 1'b1;
        trig_in = 1'b1;
        step();
        trig_in = 1'b0;
        check("R4 async low after 1 edge", 32'(a_cmd_valid), 0);
        step();
        check("R4 async low after 2 edges", 32'(a_cmd_valid), 0);
        step();
        check("R4 async high after 3 edges", 32'(a_cmd_valid), 1);
        check("R4 async entry 0", 32'(a_cmd_data), 32'(cmd_word(0)));
        check("R3 async sdo aligned", 32'(a_sdo_valid), 1);
        wait_idle();
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        load_lists(4, 3);
        t_stream();
        t_backpressure();
        t_gating();
        t_sdi();
        t_async();
        t_saturate();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule